// File: doc/BRIEF.md
# Supertiled Surface Address Generator

This block turns a pixel coordinate on a 32-bit-per-pixel render surface into a byte address. Each request carries a base address, a stride, a coordinate pair and a mode. The result leaves two clock cycles later with its own valid flag. There is no backpressure: a new request may be issued on every cycle, and requests stay in order.

The main layout is supertiled. The surface is cut into 4x4-pixel tiles of 64 bytes each, with the pixels stored row-major inside a tile. Sixteen by sixteen tiles form one 64x64-pixel supertile of 16 KiB. The tiles inside a supertile are not stored row by row. Their order comes from a one-level interleave of the tile coordinate bits. Supertiles are placed row-major across the surface. A plain tiled layout and a plain linear layout can be selected with the same ports, so the three can be compared. The stride always counts the bytes in one row of 4x4 tiles, so a surface padded to 448 pixels wide has a stride of 0x1C00.

Top module: `supertile_addr_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, outValid is 0 and outAddr is 0.
- R2: outValid is high exactly two cycles after a cycle in which inValid was sampled high, and low otherwise, so a request can be accepted on every cycle.
- R3: Mode 0 (linear) and mode 3 both give base + y*(stride/4) + 4*x, with stride/4 rounded down.
- R4: Mode 1 (tiled) gives base + (y/4)*stride + (x/4)*64 + (y%4)*16 + (x%4)*4.
- R5: Mode 2 (supertiled) gives base + (y/64)*stride*16 + (x/64)*16384 + tileIndex*64 + (y%4)*16 + (x%4)*4.
- R6: In mode 2 the tile index is built from tx=(x%64)/4 and ty=(y%64)/4. Its bit 0 is tx[0], bit 1 is ty[0], bit 2 is ty[1], bits 5:3 are tx[3:1] and bits 7:6 are ty[3:2]. For example, tile (2,14) has index 204 and tile (0,15) has index 198.
- R7: All address arithmetic wraps modulo 2^ADDR_W.
- R8: On a cycle where outValid is low, outAddr keeps its last value. A request with inValid low has no effect on outAddr.
- R9: Requests issued back to back, each in a different mode, each produce their own correct address, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A request is present this cycle |
| inMode | input | 2 | 0 linear, 1 tiled, 2 supertiled, 3 linear |
| inBase | input | ADDR_W | Surface base byte address |
| inStride | input | STRIDE_W | Bytes per row of 4x4 tiles |
| inX | input | COORD_W | Pixel column |
| inY | input | COORD_W | Pixel row |
| outValid | output | 1 | outAddr holds a new result |
| outAddr | output | ADDR_W | Computed byte address |

## Verification
The bench goes after the tile-index interleave with coordinates whose tile bits differ in only one position. A design that swaps tile-x bit 0 with tile-y bit 0, or that uses row-major or full Morton order instead of the interleave, would place those tiles 64 or more bytes away from the right spot. It also drives coordinates that cross 64-pixel and 4-pixel boundaries, stride values close to the top of their range, and bases near the top of the address space. These catch a wrong supertile row scale, a wrong intra-tile offset or a missing wraparound. Mode changes on every cycle and idle gaps show any stage that fails to carry a request's own mode, or an output that drifts while nothing is valid.

// File: rtl/supertile_pkg.sv
package supertile_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_TILED  = 2'd1,
    MODE_SUPER  = 2'd2,
    MODE_SPARE  = 2'd3
  } addrMode_e;

  // log2 sizes of the layout
  localparam int PIX_BYTES_LOG  = 2;                                   // 4 bytes per pixel
  localparam int TILE_DIM_LOG   = 2;                                   // 4x4 pixel tile
  localparam int SUPER_DIM_LOG  = 6;                                   // 64x64 pixel supertile
  localparam int TILE_BYTES_LOG = 2 * TILE_DIM_LOG + PIX_BYTES_LOG;    // 64 bytes
  localparam int SUPER_BYTES_LOG = 2 * SUPER_DIM_LOG + PIX_BYTES_LOG;  // 16 KiB
  localparam int TILES_PER_SIDE_LOG = SUPER_DIM_LOG - TILE_DIM_LOG;    // 16 tiles per side
  localparam int TILE_IDX_W = 2 * TILES_PER_SIDE_LOG;                  // 8-bit tile index
  localparam int TILE_ROW_BYTES_LOG = TILE_DIM_LOG + PIX_BYTES_LOG;    // 16 bytes per tile row

  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } stageStrobe_t;

endpackage

// File: rtl/sag_ctrl.sv
module sag_ctrl
  import supertile_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadStage1 = inValid;
    strobe.loadStage2 = stage1Valid;
  end

endmodule

// File: rtl/sag_swizzle.sv
module sag_swizzle
  import supertile_pkg::*;
(
  input  logic [TILES_PER_SIDE_LOG-1:0] tileX,
  input  logic [TILES_PER_SIDE_LOG-1:0] tileY,
  output logic [TILE_IDX_W-1:0]         tileIdx
);

  // one-level nested interleave of tile coordinate bits
  always_comb begin
    tileIdx = {tileY[3:2], tileX[3:1], tileY[1], tileY[0], tileX[0]};
  end

endmodule

// File: rtl/sag_datapath.sv
module sag_datapath
  import supertile_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 20,
  parameter int COORD_W  = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  stageStrobe_t        strobe,
  input  logic [1:0]          inMode,
  input  logic [ADDR_W-1:0]   inBase,
  input  logic [STRIDE_W-1:0] inStride,
  input  logic [COORD_W-1:0]  inX,
  input  logic [COORD_W-1:0]  inY,
  output logic [ADDR_W-1:0]   outAddr
);

  logic [TILES_PER_SIDE_LOG-1:0] tileX;
  logic [TILES_PER_SIDE_LOG-1:0] tileY;
  logic [TILE_IDX_W-1:0]         tileIdx;

  logic [ADDR_W-1:0] rowIdx;
  logic [ADDR_W-1:0] rowPitch;
  logic [ADDR_W-1:0] rowTerm;
  logic [ADDR_W-1:0] colTerm;
  logic [ADDR_W-1:0] intraTerm;
  logic [ADDR_W-1:0] strideExt;

  logic [ADDR_W-1:0] s1Base;
  logic [ADDR_W-1:0] s1Row;
  logic [ADDR_W-1:0] s1Col;

  assign tileX = inX[TILE_DIM_LOG +: TILES_PER_SIDE_LOG];
  assign tileY = inY[TILE_DIM_LOG +: TILES_PER_SIDE_LOG];

  sag_swizzle u_swizzle (
    .tileX  (tileX),
    .tileY  (tileY),
    .tileIdx(tileIdx)
  );

  assign strideExt = ADDR_W'(inStride);
  assign intraTerm = (ADDR_W'(inY[TILE_DIM_LOG-1:0]) << TILE_ROW_BYTES_LOG)
                   + (ADDR_W'(inX[TILE_DIM_LOG-1:0]) << PIX_BYTES_LOG);

  // pick the row index and pitch for the one shared multiplier
  always_comb begin
    case (addrMode_e'(inMode))
      MODE_TILED: begin
        rowIdx   = ADDR_W'(inY >> TILE_DIM_LOG);
        rowPitch = strideExt;
        colTerm  = (ADDR_W'(inX >> TILE_DIM_LOG) << TILE_BYTES_LOG) + intraTerm;
      end
      MODE_SUPER: begin
        rowIdx   = ADDR_W'(inY >> SUPER_DIM_LOG);
        rowPitch = strideExt << TILES_PER_SIDE_LOG;
        colTerm  = (ADDR_W'(inX >> SUPER_DIM_LOG) << SUPER_BYTES_LOG)
                 + (ADDR_W'(tileIdx) << TILE_BYTES_LOG) + intraTerm;
      end
      default: begin
        rowIdx   = ADDR_W'(inY);
        rowPitch = strideExt >> TILE_DIM_LOG;
        colTerm  = ADDR_W'(inX) << PIX_BYTES_LOG;
      end
    endcase
    rowTerm = rowIdx * rowPitch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Base <= '0;
      s1Row  <= '0;
      s1Col  <= '0;
    end else if (strobe.loadStage1) begin
      s1Base <= inBase;
      s1Row  <= rowTerm;
      s1Col  <= colTerm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr <= '0;
    end else if (strobe.loadStage2) begin
      outAddr <= s1Base + s1Row + s1Col;
    end
  end

endmodule

// File: rtl/supertile_addr_gen.sv
module supertile_addr_gen
  import supertile_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 20,
  parameter int COORD_W  = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [1:0]          inMode,
  input  logic [ADDR_W-1:0]   inBase,
  input  logic [STRIDE_W-1:0] inStride,
  input  logic [COORD_W-1:0]  inX,
  input  logic [COORD_W-1:0]  inY,
  output logic                outValid,
  output logic [ADDR_W-1:0]   outAddr
);

  stageStrobe_t strobe;

  sag_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  sag_datapath #(
    .ADDR_W  (ADDR_W),
    .STRIDE_W(STRIDE_W),
    .COORD_W (COORD_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inMode  (inMode),
    .inBase  (inBase),
    .inStride(inStride),
    .inX     (inX),
    .inY     (inY),
    .outAddr (outAddr)
  );

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outAddr == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outAddr));

endmodule

bind supertile_addr_gen sag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .outAddr (outAddr)
);

// File: tb/tb_supertile_addr_gen.sv
module tb_supertile_addr_gen;

  localparam int ADDR_W   = 32;
  localparam int STRIDE_W = 20;
  localparam int COORD_W  = 14;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                inValid = 1'b0;
  logic [1:0]          inMode = '0;
  logic [ADDR_W-1:0]   inBase = '0;
  logic [STRIDE_W-1:0] inStride = '0;
  logic [COORD_W-1:0]  inX = '0;
  logic [COORD_W-1:0]  inY = '0;
  logic                outValid;
  logic [ADDR_W-1:0]   outAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected pipeline: e1 = issued last negedge, e2 = two negedges ago
  bit          e1Valid = 0, e2Valid = 0;
  longint      e1Addr = 0, e2Addr = 0;
  string       e1Tag = "", e2Tag = "";
  longint      heldAddr = 0;

  always #10 clk = ~clk;

  supertile_addr_gen #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .COORD_W(COORD_W)
  ) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode),
    .inBase(inBase), .inStride(inStride), .inX(inX), .inY(inY),
    .outValid(outValid), .outAddr(outAddr)
  );

  function automatic longint modelAddr(int mode, longint base, longint stride,
                                       longint x, longint y);
    longint r, tx, ty, idx, intra;
    intra = (y % 4) * 16 + (x % 4) * 4;
    if (mode == 1) begin
      r = (y / 4) * stride + (x / 4) * 64 + intra;
    end else if (mode == 2) begin
      tx  = (x % 64) / 4;
      ty  = (y % 64) / 4;
      idx = (tx % 2) + 2 * (ty % 2) + 4 * ((ty / 2) % 2) + 8 * (tx / 2) + 64 * (ty / 4);
      r   = (y / 64) * stride * 16 + (x / 64) * 16384 + idx * 64 + intra;
    end else begin
      r = y * (stride / 4) + x * 4;
    end
    return (base + r) % (64'd1 << ADDR_W);
  endfunction

  task automatic checkOne(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: check output from two cycles ago, then drive a new request
  task automatic step(bit v, int mode, longint base, longint stride,
                      longint x, longint y, string tag, longint lit);
    longint m;
    @(negedge clk);
    checkOne("R2 outValid", outValid, e2Valid);
    if (e2Valid) begin
      checkOne(e2Tag, outAddr, e2Addr);
      heldAddr = e2Addr;
    end else begin
      checkOne("R8 hold", outAddr, heldAddr);
    end
    e2Valid = e1Valid; e2Addr = e1Addr; e2Tag = e1Tag;
    inValid  = v;
    inMode   = 2'(mode);
    inBase   = ADDR_W'(base);
    inStride = STRIDE_W'(stride);
    inX      = COORD_W'(x);
    inY      = COORD_W'(y);
    m = modelAddr(mode, base, stride, x, y);
    if (v && lit >= 0) checkOne({tag, " model"}, m, lit);
    e1Valid = v; e1Addr = m; e1Tag = tag;
  endtask

  function automatic string modeTag(int mode);
    case (mode)
      1: return "R4 tiled";
      2: return "R5 supertiled";
      default: return "R3 linear";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checkOne("R1 reset valid", outValid, 0);
    checkOne("R1 reset addr", outAddr, 0);
    @(negedge clk);
    rst = 0;
    checkOne("R1 after reset valid", outValid, 0);
    checkOne("R1 after reset addr", outAddr, 0);

    // R6 directed tile-index points (448-wide surface)
    step(1, 2, 0, 'h1C00, 8, 56, "R6 tile(2,14)", 13056);
    step(1, 2, 0, 'h1C00, 0, 60, "R6 tile(0,15)", 12672);
    step(1, 2, 0, 'h1C00, 4, 0, "R6 tx bit0", 64);
    step(1, 2, 0, 'h1C00, 0, 4, "R6 ty bit0", 128);
    step(1, 2, 0, 'h1C00, 0, 8, "R6 ty bit1", 256);
    step(1, 2, 0, 'h1C00, 8, 0, "R6 tx bit1", 512);
    step(1, 2, 0, 'h1C00, 0, 16, "R6 ty bit2", 4096);
    // R5 supertile offsets plus intra-tile offset
    step(1, 2, 'h1000_0000, 'h1C00, 70, 130, "R5 supertiled", -1);
    // R4 tiled and R3 linear, including spare mode 3
    step(1, 1, 'h100, 'h3400, 13, 7, "R4 tiled", 'h100 + 'h3400 + 3*64 + 3*16 + 4);
    step(1, 0, 'h100, 'h3400, 13, 7, "R3 linear", 'h100 + 7*'hD00 + 52);
    step(1, 3, 'h100, 'h3400, 13, 7, "R3 spare mode", 'h100 + 7*'hD00 + 52);
    // R7 wraparound
    step(1, 0, 'hFFFF_FFF0, 'h40, 8, 0, "R7 wrap", 'h10);
    step(1, 2, 'hFFFF_C000, 'hFFFFC, 16383, 16383, "R7 wrap", -1);
    // R8 idle gap with junk inputs
    step(0, 2, 'hDEAD_BEEF, 'h123, 99, 99, "R8 ignored", -1);
    step(0, 1, 'h1234_5678, 'h777, 5, 5, "R8 ignored", -1);
    step(0, 0, 0, 0, 0, 0, "R8 ignored", -1);

    // R9 back-to-back mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int mode;
      bit v;
      mode = int'($urandom_range(0, 3));
      v = ($urandom_range(0, 7) != 0);
      step(v, mode, longint'($urandom), longint'($urandom_range(0, (1 << STRIDE_W) - 1)),
           longint'($urandom_range(0, (1 << COORD_W) - 1)),
           longint'($urandom_range(0, (1 << COORD_W) - 1)),
           (i % 2 == 0) ? "R9 mixed" : modeTag(mode), -1);
    end
    step(0, 0, 0, 0, 0, 0, "drain", -1);
    step(0, 0, 0, 0, 0, 0, "drain", -1);
    step(0, 0, 0, 0, 0, 0, "drain", -1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule